// File: doc/BRIEF.md
# Two-Way Data Cache with Virtual Set Select and Physical Tag Match

This block is the data cache that sits behind a load/store unit. Each request carries the set index and byte offset from the untranslated address, and the physical tag arrives in the same cycle from the translation stage. The index selects one set. Both ways of that set are read, and both stored tags are compared with the physical tag in parallel. On a hit, the word from the matching way goes straight back to the requester in the same cycle. The default geometry is 512 sets of 64-byte lines in two ways (64 KB). Physical addresses are 44 bits wide, so each stored tag holds 29 bits.

Stores follow a write-back, write-allocate policy. A store hit changes only the cached line and marks it dirty. On a miss of either kind, a victim is chosen from the selected set. A dirty victim is first sent to memory as a full line. The missing line is then read over a line-wide memory port with a valid/ready request handshake and a response strobe. The waiting access completes in the cycle the refill data arrives: a load's word is taken from the incoming line, and a store's word is merged into the line as it is installed. While a miss is in progress the stall output stays high, and the requester holds its request steady. Only one miss is in progress at a time.

Top module: `vidx_dcache`

## Requirements
- R1: A request hits when either way of the set chosen by `req_index` is valid and holds a tag equal to `req_ptag`. A hit gives `rsp_valid`=1 and `stall`=0 in the request cycle, with `rsp_rdata` set to word `req_offset[5:2]` of the hitting line. `req_offset[1:0]` is ignored, and a hit creates no memory traffic.
- R2: The line address on the memory port is {tag, index}, which is 38 bits. A line is 512 bits wide, and word k sits at bits [32k+31:32k].
- R3: A store hit replaces only the addressed word of the hitting line and marks the line dirty. It creates no memory traffic.
- R4: A miss whose victim is invalid or clean creates no write request. It issues exactly one read request with address {req_ptag, req_index}.
- R5: A miss whose victim is valid and dirty first issues a write request. That request carries address {victim tag, index} and the victim's full line as data. The read request for the missing line follows in the cycle after the write handshake.
- R6: A store miss reads the whole line from memory and replaces only the addressed word with the store data. The installed line is dirty, so a later eviction writes the merged line back.
- R7: The victim is chosen in this order: way 0 if it is invalid, otherwise way 1 if it is invalid, otherwise the least recently used way of the set. Recency is kept as one bit per set, updated by every hit and every fill.
- R8: `stall` is high from the cycle a miss is presented until the refill response arrives. In that response cycle, `stall` is 0 and `rsp_valid` is 1, and a load returns the requested word of the refill line. `rsp_valid` and `stall` are never high together, and a memory request is only raised while `stall` is high.
- R9: `mem_req_valid`, `mem_req_we` and `mem_req_addr` hold steady until `mem_req_ready` is seen high.
- R10: Reset clears every valid, dirty and recency bit. After reset, every access misses and no write request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present (held while `stall` is high) |
| req_we | input | 1 | 1 = store, 0 = load |
| req_index | input | 9 | Set index from the untranslated address |
| req_offset | input | 6 | Byte offset within the line |
| req_ptag | input | 29 | Physical tag for the compare |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Access completes this cycle |
| rsp_rdata | output | 32 | Load data |
| stall | output | 1 | Miss in progress; requester must hold |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_we | output | 1 | 1 = line writeback, 0 = line read |
| mem_req_addr | output | 38 | Line address {tag, index} |
| mem_req_wdata | output | 512 | Writeback line data |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Refill line data valid |
| mem_rsp_data | input | 512 | Refill line data |

## Verification
The refill install and the completion of the waiting access happen in one cycle. If the access is a store, the write-allocate merge and the setting of the dirty bit also fall into that same cycle. The bench provokes this with a store miss. It reads back both the stored word and a neighbouring word, which must come from the memory image. It then fills the other way and misses a third tag into the set, forcing that line out as the LRU victim. The write request must carry the merged line. A refill that dropped the store, or lost the dirty bit, would show up either as a wrong read-back or as a missing write request.

// File: rtl/vidx_pkg.sv
package vidx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FETCH = 2'd2,
    ST_WAIT  = 2'd3
  } vidx_state_e;

endpackage

// File: rtl/vidx_way.sv
// Storage for one way: tag and line arrays (no reset), valid and dirty
// vectors (reset). Asynchronous read, single write port.
module vidx_way #(
  parameter int IDX_W  = 9,
  parameter int TAG_W  = 29,
  parameter int LINE_W = 512,
  localparam int SETS  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              rd_vld,
  output logic              rd_dty,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              wr_dty
);

  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];
  logic [SETS-1:0]   vld_q, vld_d;
  logic [SETS-1:0]   dty_q, dty_d;

  always_comb begin
    vld_d = vld_q;
    dty_d = dty_q;
    if (wr_en) begin
      vld_d[wr_idx] = 1'b1;
      dty_d[wr_idx] = wr_dty;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dty_q <= '0;
    end else if (wr_en) begin
      vld_q <= vld_d;
      dty_q <= dty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      line_mem[wr_idx] <= wr_line;
    end
  end

  assign rd_tag  = tag_mem[rd_idx];
  assign rd_line = line_mem[rd_idx];
  assign rd_vld  = vld_q[rd_idx];
  assign rd_dty  = dty_q[rd_idx];

endmodule

// File: rtl/vidx_lru.sv
// One recency bit per set: the bit names the way to evict next.
// Invalid ways are preferred over the recency choice.
module vidx_lru #(
  parameter int IDX_W = 9,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             vld0,
  input  logic             vld1,
  output logic             victim,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic             upd_way
);

  logic [SETS-1:0] old_q, old_d;

  always_comb begin
    if (!vld0)      victim = 1'b0;
    else if (!vld1) victim = 1'b1;
    else            victim = old_q[rd_idx];
  end

  always_comb begin
    old_d = old_q;
    if (upd_en) old_d[upd_idx] = ~upd_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      old_q <= '0;
    else if (upd_en) old_q <= old_d;
  end

endmodule

// File: rtl/vidx_ctrl.sv
// Miss sequencer: idle -> (evict) -> fetch -> wait for refill -> idle.
module vidx_ctrl
  import vidx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        hit,
  input  logic        vic_dirty,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  output vidx_state_e state,
  output logic        miss_cap
);

  vidx_state_e state_d;

  always_comb begin
    state_d  = state;
    miss_cap = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid && !hit) begin
          miss_cap = 1'b1;
          state_d  = vic_dirty ? ST_EVICT : ST_FETCH;
        end
      end
      ST_EVICT: if (mem_req_ready) state_d = ST_FETCH;
      ST_FETCH: if (mem_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (mem_rsp_valid) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end

endmodule

// File: rtl/vidx_dcache.sv
module vidx_dcache
  import vidx_pkg::*;
#(
  parameter int IDX_W   = 9,
  parameter int OFF_W   = 6,
  parameter int PA_W    = 44,
  parameter int WORD_W  = 32,
  localparam int TAG_W  = PA_W - IDX_W - OFF_W,
  localparam int LINE_W = 8 * (1 << OFF_W),
  localparam int LA_W   = TAG_W + IDX_W,
  localparam int BSEL_W = $clog2(WORD_W / 8),
  localparam int WSEL_W = OFF_W - BSEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [TAG_W-1:0]  req_ptag,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              stall,
  output logic              mem_req_valid,
  output logic              mem_req_we,
  output logic [LA_W-1:0]   mem_req_addr,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_data
);

  localparam int WAYS = 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic unused_byte_bits;
  assign unused_byte_bits = ^req_offset[BSEL_W-1:0];

  vidx_state_e state;
  logic        miss_cap;
  logic        idle;
  assign idle = (state == ST_IDLE);

  // captured miss context
  logic              lat_we;
  logic [IDX_W-1:0]  lat_idx;
  logic [TAG_W-1:0]  lat_tag;
  logic [WSEL_W-1:0] lat_wsel;
  logic [WORD_W-1:0] lat_wdata;
  logic              lat_way;

  logic              cur_we;
  logic [IDX_W-1:0]  cur_idx;
  logic [TAG_W-1:0]  cur_tag;
  logic [WSEL_W-1:0] cur_wsel;
  logic [WORD_W-1:0] cur_wdata;

  assign cur_we    = idle ? req_we    : lat_we;
  assign cur_idx   = idle ? req_index : lat_idx;
  assign cur_tag   = idle ? req_ptag  : lat_tag;
  assign cur_wsel  = idle ? req_offset[OFF_W-1:BSEL_W] : lat_wsel;
  assign cur_wdata = idle ? req_wdata : lat_wdata;

  // way storage and parallel compare
  logic [TAG_W-1:0]  way_tag  [WAYS];
  logic [LINE_W-1:0] way_line [WAYS];
  logic [WAYS-1:0]   way_vld, way_dty, hit_w, wr_en_w;
  logic [TAG_W-1:0]  wr_tag;
  logic [LINE_W-1:0] wr_line;
  logic              wr_dty;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    vidx_way #(
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .LINE_W (LINE_W)
    ) u_way (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .rd_idx  (cur_idx),
      .rd_tag  (way_tag[w]),
      .rd_vld  (way_vld[w]),
      .rd_dty  (way_dty[w]),
      .rd_line (way_line[w]),
      .wr_en   (wr_en_w[w]),
      .wr_idx  (cur_idx),
      .wr_tag  (wr_tag),
      .wr_line (wr_line),
      .wr_dty  (wr_dty)
    );
    assign hit_w[w] = way_vld[w] && (way_tag[w] == cur_tag);
  end

  logic hit_any, hit_way, victim, vic_dirty;
  logic lru_upd, lru_way;

  assign hit_any   = |hit_w;
  assign hit_way   = hit_w[1];
  assign vic_dirty = way_vld[victim] && way_dty[victim];

  vidx_lru #(.IDX_W(IDX_W)) u_lru (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .rd_idx  (cur_idx),
    .vld0    (way_vld[0]),
    .vld1    (way_vld[1]),
    .victim  (victim),
    .upd_en  (lru_upd),
    .upd_idx (cur_idx),
    .upd_way (lru_way)
  );

  vidx_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .req_valid     (req_valid),
    .hit           (hit_any),
    .vic_dirty     (vic_dirty),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .state         (state),
    .miss_cap      (miss_cap)
  );

  always_ff @(posedge clk) begin
    if (miss_cap) begin
      lat_we    <= req_we;
      lat_idx   <= req_index;
      lat_tag   <= req_ptag;
      lat_wsel  <= req_offset[OFF_W-1:BSEL_W];
      lat_wdata <= req_wdata;
      lat_way   <= victim;
    end
  end

  // access completion: hit in idle, or refill arrival in wait
  logic              hit_done, fill_done;
  logic [LINE_W-1:0] base_line, merged_line;

  assign hit_done  = idle && req_valid && hit_any;
  assign fill_done = (state == ST_WAIT) && mem_rsp_valid;
  assign base_line = idle ? way_line[hit_way] : mem_rsp_data;

  always_comb begin
    merged_line = base_line;
    merged_line[cur_wsel*WORD_W +: WORD_W] = cur_wdata;
  end

  always_comb begin
    wr_en_w = '0;
    wr_tag  = cur_tag;
    wr_line = cur_we ? merged_line : base_line;
    wr_dty  = cur_we;
    lru_upd = 1'b0;
    lru_way = hit_way;
    if (hit_done) begin
      wr_en_w[hit_way] = cur_we;
      lru_upd          = 1'b1;
    end else if (fill_done) begin
      wr_en_w[lat_way] = 1'b1;
      lru_upd          = 1'b1;
      lru_way          = lat_way;
    end
  end

  assign rsp_valid = hit_done || fill_done;
  assign rsp_rdata = base_line[cur_wsel*WORD_W +: WORD_W];
  assign stall     = (idle && req_valid && !hit_any) ||
                     (state == ST_EVICT) || (state == ST_FETCH) ||
                     ((state == ST_WAIT) && !mem_rsp_valid);

  assign mem_req_valid = (state == ST_EVICT) || (state == ST_FETCH);
  assign mem_req_we    = (state == ST_EVICT);
  assign mem_req_addr  = (state == ST_EVICT) ? {way_tag[lat_way], lat_idx}
                                             : {lat_tag, lat_idx};
  assign mem_req_wdata = (state == ST_EVICT) ? way_line[lat_way] : '0;

endmodule

// File: rtl/vidx_dcache_chk.sv
module vidx_dcache_chk #(
  parameter int LA_W = 38
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stall,
  input logic            rsp_valid,
  input logic            mem_req_valid,
  input logic            mem_req_we,
  input logic            mem_req_ready,
  input logic [LA_W-1:0] mem_req_addr
);

  p_rsp_not_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !stall);

  p_memreq_only_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> stall);

  p_memreq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));

  p_fetch_after_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we && mem_req_ready) |=> (mem_req_valid && !mem_req_we));

  p_single_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_we && mem_req_ready) |=> !mem_req_valid);

endmodule

bind vidx_dcache vidx_dcache_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .stall         (stall),
  .rsp_valid     (rsp_valid),
  .mem_req_valid (mem_req_valid),
  .mem_req_we    (mem_req_we),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr)
);

// File: tb/vidx_dcache_tb_top.sv
`timescale 1ns/1ps
module vidx_dcache_tb_top;

  localparam int IDX_W = 9, OFF_W = 6, WORD_W = 32;
  localparam int TAG_W = 29, LINE_W = 512, LA_W = 38;

  logic clk, rst_n;
  logic req_valid, req_we;
  logic [IDX_W-1:0]  req_index;
  logic [OFF_W-1:0]  req_offset;
  logic [TAG_W-1:0]  req_ptag;
  logic [WORD_W-1:0] req_wdata;
  logic              rsp_valid, stall;
  logic [WORD_W-1:0] rsp_rdata;
  logic              mem_req_valid, mem_req_we, mem_req_ready, mem_rsp_valid;
  logic [LA_W-1:0]   mem_req_addr;
  logic [LINE_W-1:0] mem_req_wdata, mem_rsp_data;

  vidx_dcache dut_i (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  int rdy_lat  = 0;
  int wb_cnt   = 0;
  int rd_cnt   = 0;
  logic [LA_W-1:0]   last_wb_addr, last_rd_addr;
  logic [LINE_W-1:0] last_wb_data;
  logic [LINE_W-1:0] mem_store [logic [LA_W-1:0]];

  localparam logic [TAG_W-1:0] TA = 29'h0123, TB = 29'h0456, TC = 29'h0789,
    TD = 29'h0ABC, TE = 29'h0DEF, TF = 29'h0135, TG = 29'h0246,
    TH = 29'h0357, TI = 29'h0468;

  function automatic logic [LINE_W-1:0] init_line(input logic [LA_W-1:0] la);
    logic [LINE_W-1:0] l;
    for (int k = 0; k < 16; k++)
      l[k*32 +: 32] = {la[19:0], 8'h00, 4'(k)} ^ 32'h3C00_0000;
    return l;
  endfunction

  function automatic logic [31:0] ref_word(input logic [TAG_W-1:0] t,
                                            input logic [IDX_W-1:0] i, input int k);
    logic [LINE_W-1:0] l;
    l = init_line({t, i});
    return l[k*32 +: 32];
  endfunction

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [LA_W-1:0]   a_s;
        logic              we_s;
        logic [LINE_W-1:0] d_s;
        logic              steady;
        a_s = mem_req_addr; we_s = mem_req_we; d_s = mem_req_wdata; steady = 1'b1;
        for (int c = 0; c < rdy_lat; c++) begin
          @(negedge clk);
          if (!mem_req_valid || mem_req_addr !== a_s || mem_req_we !== we_s) steady = 1'b0;
        end
        chk("R9", "request held until ready", {63'd0, steady}, 64'd1);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (we_s) begin
          mem_store[a_s] = d_s;
          wb_cnt++; last_wb_addr = a_s; last_wb_data = d_s;
        end else begin
          rd_cnt++; last_rd_addr = a_s;
          @(negedge clk);
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = mem_store.exists(a_s) ? mem_store[a_s] : init_line(a_s);
          @(negedge clk);
          mem_rsp_valid = 1'b0;
        end
      end
    end
  end

  task automatic access(input logic we, input logic [IDX_W-1:0] idx,
                        input logic [TAG_W-1:0] tag, input logic [OFF_W-1:0] off,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output int waits, output logic stall_ok);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_index = idx; req_ptag = tag;
    req_offset = off; req_wdata = wd;
    #1;
    waits = 0; stall_ok = 1'b1;
    while (!rsp_valid && waits < 500) begin
      if (!stall) stall_ok = 1'b0;
      @(negedge clk); #1;
      waits++;
    end
    rd = rsp_rdata;
    if (stall) stall_ok = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0;
    req_index = '0; req_offset = '0; req_ptag = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    #1;
    chk("R10", "stall idle", {63'd0, stall}, 64'd0);
    chk("R10", "rsp idle", {63'd0, rsp_valid}, 64'd0);
    chk("R10", "no mem req", {63'd0, mem_req_valid}, 64'd0);
  endtask

  task automatic t_read_miss_hit();
    logic [31:0] rd; int w; logic ok; int rc, wc;
    rc = rd_cnt; wc = wb_cnt;
    access(1'b0, 9'd5, TA, 6'h08, 32'h0, rd, w, ok);
    chk("R8", "miss load data", rd, ref_word(TA, 9'd5, 2));
    chk("R8", "miss stalled", {63'd0, ok && (w > 0)}, 64'd1);
    chk("R4", "one read", rd_cnt - rc, 1);
    chk("R4", "no writeback", wb_cnt - wc, 0);
    chk("R2", "read addr", last_rd_addr, {TA, 9'd5});
    rc = rd_cnt;
    access(1'b0, 9'd5, TA, 6'h3D, 32'h0, rd, w, ok);
    chk("R1", "hit word15 low bits ignored", rd, ref_word(TA, 9'd5, 15));
    chk("R1", "hit no wait", w, 0);
    chk("R1", "hit no traffic", rd_cnt - rc, 0);
  endtask

  task automatic t_store_hit();
    logic [31:0] rd; int w; logic ok; int rc, wc;
    rc = rd_cnt; wc = wb_cnt;
    access(1'b1, 9'd5, TA, 6'h0C, 32'hDEAD_BEEF, rd, w, ok);
    chk("R3", "store hit no wait", w, 0);
    chk("R3", "store hit no traffic", (rd_cnt - rc) + (wb_cnt - wc), 0);
    access(1'b0, 9'd5, TA, 6'h0C, 32'h0, rd, w, ok);
    chk("R3", "stored word", rd, 32'hDEAD_BEEF);
    access(1'b0, 9'd5, TA, 6'h10, 32'h0, rd, w, ok);
    chk("R3", "neighbour word", rd, ref_word(TA, 9'd5, 4));
  endtask

  task automatic t_lru_evict();
    logic [31:0] rd; int w; logic ok; int wc;
    wc = wb_cnt;
    access(1'b0, 9'd5, TB, 6'h00, 32'h0, rd, w, ok);
    chk("R7", "second way fill no wb", wb_cnt - wc, 0);
    chk("R7", "second way data", rd, ref_word(TB, 9'd5, 0));
    access(1'b0, 9'd5, TA, 6'h0C, 32'h0, rd, w, ok);
    chk("R1", "both ways resident", {32'(w), rd}, {32'd0, 32'hDEAD_BEEF});
    access(1'b0, 9'd5, TC, 6'h04, 32'h0, rd, w, ok);
    chk("R7", "LRU clean victim no wb", wb_cnt - wc, 0);
    access(1'b0, 9'd5, TC, 6'h04, 32'h0, rd, w, ok);
    chk("R7", "new line resident", w, 0);
    access(1'b0, 9'd5, TB, 6'h00, 32'h0, rd, w, ok);
    chk("R5", "dirty victim written", wb_cnt - wc, 1);
    chk("R5", "wb addr", last_wb_addr, {TA, 9'd5});
    chk("R5", "wb stored word", last_wb_data[3*32 +: 32], 32'hDEAD_BEEF);
    chk("R5", "wb other word", last_wb_data[4*32 +: 32], ref_word(TA, 9'd5, 4));
    access(1'b0, 9'd5, TA, 6'h0C, 32'h0, rd, w, ok);
    chk("R5", "written data returns", rd, 32'hDEAD_BEEF);
    chk("R7", "clean LRU victim no wb", wb_cnt - wc, 1);
  endtask

  task automatic t_store_miss();
    logic [31:0] rd; int w; logic ok; int rc, wc;
    rc = rd_cnt; wc = wb_cnt;
    access(1'b1, 9'd7, TD, 6'h24, 32'h1234_5678, rd, w, ok);
    chk("R6", "store miss stalls", {63'd0, ok && (w > 0)}, 64'd1);
    chk("R6", "allocate read", {32'(rd_cnt - rc), 32'(wb_cnt - wc)}, {32'd1, 32'd0});
    chk("R6", "allocate addr", last_rd_addr, {TD, 9'd7});
    access(1'b0, 9'd7, TD, 6'h24, 32'h0, rd, w, ok);
    chk("R6", "merged word", {32'(w), rd}, {32'd0, 32'h1234_5678});
    access(1'b0, 9'd7, TD, 6'h20, 32'h0, rd, w, ok);
    chk("R6", "refill word", rd, ref_word(TD, 9'd7, 8));
    access(1'b0, 9'd7, TE, 6'h00, 32'h0, rd, w, ok);
    chk("R7", "invalid way filled first", wb_cnt - wc, 0);
    access(1'b0, 9'd7, TF, 6'h00, 32'h0, rd, w, ok);
    chk("R6", "allocated line dirty", wb_cnt - wc, 1);
    chk("R6", "wb addr", last_wb_addr, {TD, 9'd7});
    chk("R6", "wb merged", last_wb_data[9*32 +: 32], 32'h1234_5678);
    chk("R6", "wb refill word", last_wb_data[8*32 +: 32], ref_word(TD, 9'd7, 8));
  endtask

  task automatic t_slow_memory();
    logic [31:0] rd; int w; logic ok; int wc;
    rdy_lat = 3;
    wc = wb_cnt;
    access(1'b0, 9'd9, TG, 6'h00, 32'h0, rd, w, ok);
    chk("R8", "slow refill stall held", {63'd0, ok && (w >= 5)}, 64'd1);
    chk("R8", "slow refill data", rd, ref_word(TG, 9'd9, 0));
    access(1'b1, 9'd9, TG, 6'h3C, 32'hA5A5_0F0F, rd, w, ok);
    access(1'b0, 9'd9, TH, 6'h00, 32'h0, rd, w, ok);
    access(1'b0, 9'd9, TI, 6'h00, 32'h0, rd, w, ok);
    chk("R9", "slow writeback", {32'(wb_cnt - wc), last_wb_data[15*32 +: 32]},
        {32'd1, 32'hA5A5_0F0F});
    chk("R9", "slow wb addr", last_wb_addr, {TG, 9'd9});
    rdy_lat = 0;
  endtask

  task automatic t_reset_clears();
    logic [31:0] rd; int w; logic ok; int rc, wc;
    access(1'b1, 9'd7, TF, 6'h08, 32'hCAFE_F00D, rd, w, ok);
    chk("R3", "store hit before reset", w, 0);
    do_reset();
    rc = rd_cnt; wc = wb_cnt;
    access(1'b0, 9'd7, TF, 6'h08, 32'h0, rd, w, ok);
    chk("R10", "miss after reset", {63'd0, w > 0}, 64'd1);
    chk("R10", "dirty cleared no wb", wb_cnt - wc, 0);
    chk("R10", "fresh data", rd, ref_word(TF, 9'd7, 2));
    chk("R10", "one read", rd_cnt - rc, 1);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    t_reset();
    t_read_miss_hit();
    t_store_hit();
    t_lru_evict();
    t_store_miss();
    t_slow_memory();
    t_reset_clears();
    repeat (4) @(negedge clk);
    summary();
  end

endmodule